// File: doc/BRIEF.md
# Cascaded Triplicated Pipeline with Distributed Voting

This block is a short pipeline in which every stage is built three times over. Each stage holds three identical replica registers that load an incremented copy of their lane input. Three independent bitwise majority voters look at the three replica outputs. Each voter drives exactly one replica lane of the following stage. A voter that goes wrong therefore spoils only one of three lanes downstream, where the next vote removes it, so no voter inside the chain is a single point of failure. One end voter combines the three lanes of the last stage into the data output.

Data enters with a valid flag and leaves, incremented once per stage, a fixed number of cycles later with its own valid flag. Every replica output and every voter output can be corrupted on purpose through XOR masks on dedicated input ports. Each stage reports a disagreement flag, so a bench or a monitor can inject a fault and see both that it was masked and where it was noticed.

Top module: `tmr_cascade`

## Requirements
- R1: While reset is low and right after it is released, out_valid is 0, out_data is 0 and every bit of stage_mismatch is 0, provided no fault masks are set.
- R2: A word presented with in_valid high at a rising edge shows up with out_valid high after exactly STAGES rising edges. out_valid is high for one cycle per accepted word and never high when no word was accepted STAGES edges earlier.
- R3: Each stage adds 1 modulo 2^W to its lane value, so out_data equals the accepted word plus STAGES, wrapping (default 0xFE gives 0x01).
- R4: Every voter computes the bitwise majority (a AND b) OR (b AND c) OR (a AND c). If two replicas of one stage are corrupted on the same bits, those bits come out inverted.
- R5: A fault mask on any single replica output leaves out_data correct. The mask for stage s, replica r sits in rep_fault bits [(s*3+r)*W +: W].
- R6: A fault mask on any single voter output, including a voter of the last stage, leaves out_data correct. The mask for stage s, voter v sits in vot_fault bits [(s*3+v)*W +: W]. Voter v of stage s feeds replica v of stage s+1.
- R7: stage_mismatch[s] is 1 exactly when at least one of the three replica outputs of stage s, masks included, differs from their bitwise majority.
- R8: With at most one corrupted replica lane per stage, counting lanes spoiled by an upstream voter, out_data stays correct even when every stage has a fault at the same time.
- R9: When a stage is not loaded, because in_valid is low or no valid word reached it, its replicas hold their value. With in_valid low, in_data has no effect, and out_data holds while fault masks are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word qualifier, loads stage 0 |
| in_data | input | W | Input word |
| rep_fault | input | STAGES*3*W | XOR masks on replica outputs, one W-bit field per stage and replica |
| vot_fault | input | STAGES*3*W | XOR masks on voter outputs, one W-bit field per stage and voter |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | W | End-voter result |
| stage_mismatch | output | STAGES | Per-stage replica disagreement flag |

## Verification
The bench hunts for cases where the fault lands on the lane that decides the result. It injects faults into the last stage, where only the end voter can mask them. It corrupts a voter whose bad lane travels one stage further before a vote removes it. It also faults one lane in every stage at once. A design that wired a voter to more than one downstream replica, or that used a single shared voter, would let one of these faults through to out_data. Two faults on the same bits of one stage must invert exactly those bits; a voter that used OR or AND in place of majority would get this wrong. The bench also checks that a stage with no valid word holds its value and ignores in_data, and that the disagreement flag rises in the stage that received a bad voter lane, not in the stage that produced it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Replication factor of every stage: three replicas, three voters.
  localparam int unsigned LANES = 3;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] flip,
  output logic [W-1:0] y
);
  logic [W-1:0] maj;

  always_comb begin
    maj = (a & b) | (b & c) | (a & c);
    y   = maj ^ flip;
  end
endmodule

// File: rtl/tmr_replica.sv
module tmr_replica #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  input  logic [W-1:0] flip,
  output logic [W-1:0] q_out
);
  logic [W-1:0] q;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign q_out = q ^ flip;
endmodule

// File: rtl/tmr_stage.sv
module tmr_stage
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [LANES*W-1:0] lane_in,
  input  logic [LANES*W-1:0] rep_flip,
  input  logic [LANES*W-1:0] vot_flip,
  output logic [LANES*W-1:0] lane_out,
  output logic               mismatch
);
  logic [W-1:0] rep_q [LANES];
  logic [W-1:0] ref_maj;
  logic [W-1:0] diff;

  for (genvar r = 0; r < LANES; r++) begin : g_rep
    tmr_replica #(.W(W)) u_rep (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .d     (lane_in[r*W +: W]),
      .flip  (rep_flip[r*W +: W]),
      .q_out (rep_q[r])
    );
  end

  for (genvar v = 0; v < LANES; v++) begin : g_vot
    tmr_voter #(.W(W)) u_vot (
      .a    (rep_q[0]),
      .b    (rep_q[1]),
      .c    (rep_q[2]),
      .flip (vot_flip[v*W +: W]),
      .y    (lane_out[v*W +: W])
    );
  end

  // Uncorrupted reference vote used only for the disagreement flag.
  tmr_voter #(.W(W)) u_ref (
    .a    (rep_q[0]),
    .b    (rep_q[1]),
    .c    (rep_q[2]),
    .flip ('0),
    .y    (ref_maj)
  );

  always_comb begin
    diff     = (rep_q[0] ^ ref_maj) | (rep_q[1] ^ ref_maj) | (rep_q[2] ^ ref_maj);
    mismatch = |diff;
  end
endmodule

// File: rtl/tmr_cascade.sv
module tmr_cascade
  import tmr_pkg::*;
#(
  parameter int unsigned STAGES = 3,
  parameter int unsigned W      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [W-1:0]              in_data,
  input  logic [STAGES*LANES*W-1:0] rep_fault,
  input  logic [STAGES*LANES*W-1:0] vot_fault,
  output logic                      out_valid,
  output logic [W-1:0]              out_data,
  output logic [STAGES-1:0]         stage_mismatch
);
  localparam int unsigned SW = LANES * W;

  logic [SW-1:0]     lane [STAGES+1];
  logic [STAGES-1:0] stage_en;
  logic [STAGES-1:0] vld;
  logic [STAGES-1:0] vld_nxt;

  assign lane[0] = {LANES{in_data}};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_en[s] = in_valid;
    end else begin : g_next
      assign stage_en[s] = vld[s-1];
    end

    tmr_stage #(.W(W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (stage_en[s]),
      .lane_in  (lane[s]),
      .rep_flip (rep_fault[s*SW +: SW]),
      .vot_flip (vot_fault[s*SW +: SW]),
      .lane_out (lane[s+1]),
      .mismatch (stage_mismatch[s])
    );
  end

  always_comb vld_nxt = stage_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= vld_nxt;
  end

  assign out_valid = vld[STAGES-1];

  tmr_voter #(.W(W)) u_end (
    .a    (lane[STAGES][0*W +: W]),
    .b    (lane[STAGES][1*W +: W]),
    .c    (lane[STAGES][2*W +: W]),
    .flip ('0),
    .y    (out_data)
  );
endmodule

// File: rtl/tmr_cascade_chk.sv
module tmr_cascade_chk #(
  parameter int unsigned STAGES = 3,
  parameter int unsigned W      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic [W-1:0]          out_data,
  input logic [STAGES*3*W-1:0] rep_fault,
  input logic [STAGES*3*W-1:0] vot_fault,
  input logic [STAGES-1:0]     stage_mismatch,
  input logic [3*W-1:0]        last_lanes,
  input logic                  last_en
);
  localparam int unsigned CW = $clog2(STAGES + 1);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       idle_cnt <= CW'(STAGES);
    else if (in_valid)                idle_cnt <= '0;
    else if (idle_cnt < CW'(STAGES))  idle_cnt <= idle_cnt + CW'(1);
  end

  // R1: nothing valid leaves the block in the first cycle after reset.
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R2: with no word accepted for STAGES cycles, no output is valid.
  a_r2_idle_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt >= CW'(STAGES)) |-> !out_valid);

  // R7: stage 0 replicas share one input, so they disagree only under a replica fault.
  a_r7_stage0_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_fault[3*W-1:0] == '0) |-> !stage_mismatch[0]);

  // R4: when all last-stage voters agree, the end voter passes that value.
  a_r4_unanimous_end: assert property (@(posedge clk) disable iff (!rst_n)
    ((last_lanes[0 +: W] == last_lanes[W +: W]) && (last_lanes[W +: W] == last_lanes[2*W +: W]))
      |-> (out_data == last_lanes[0 +: W]));

  // R9: an unloaded last stage with unchanged masks keeps out_data.
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!last_en) && $stable(rep_fault) && $stable(vot_fault)) |-> $stable(out_data));
endmodule

bind tmr_cascade tmr_cascade_chk #(.STAGES(STAGES), .W(W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .out_valid      (out_valid),
  .out_data       (out_data),
  .rep_fault      (rep_fault),
  .vot_fault      (vot_fault),
  .stage_mismatch (stage_mismatch),
  .last_lanes     (lane[STAGES]),
  .last_en        (stage_en[STAGES-1])
);

// File: tb/tmr_cascade_tb.sv
module tmr_cascade_tb;
  localparam int S = 3;
  localparam int W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [W-1:0]     in_data = '0;
  logic [S*3*W-1:0] rep_f = '0;
  logic [S*3*W-1:0] vot_f = '0;
  logic             out_valid;
  logic [W-1:0]     out_data;
  logic [S-1:0]     stage_mismatch;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0] m_q [S][3];
  bit           m_v [S];

  always #10 clk = ~clk;

  tmr_cascade #(.STAGES(S), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rep_fault(rep_f), .vot_fault(vot_f),
    .out_valid(out_valid), .out_data(out_data), .stage_mismatch(stage_mismatch)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] vote_of(input logic [W-1:0] a, b, c);
    logic [W-1:0] res = '0;
    for (int i = 0; i < W; i++) begin
      int ones = int'(a[i]) + int'(b[i]) + int'(c[i]);
      res[i] = (ones >= 2);
    end
    return res;
  endfunction

  function automatic logic [W-1:0] rep_o(input int s, input int r);
    return m_q[s][r] ^ rep_f[(s*3+r)*W +: W];
  endfunction

  function automatic logic [W-1:0] vot_o(input int s, input int v);
    return vote_of(rep_o(s,0), rep_o(s,1), rep_o(s,2)) ^ vot_f[(s*3+v)*W +: W];
  endfunction

  function automatic logic [W-1:0] m_out();
    return vote_of(vot_o(S-1,0), vot_o(S-1,1), vot_o(S-1,2));
  endfunction

  function automatic bit m_mis(input int s);
    logic [W-1:0] mj = vote_of(rep_o(s,0), rep_o(s,1), rep_o(s,2));
    return (rep_o(s,0) != mj) || (rep_o(s,1) != mj) || (rep_o(s,2) != mj);
  endfunction

  task automatic model_edge();
    logic [W-1:0] nq [S][3];
    bit           nv [S];
    for (int s = 0; s < S; s++) begin
      bit en = (s == 0) ? bit'(in_valid) : m_v[s-1];
      nv[s] = en;
      for (int r = 0; r < 3; r++) begin
        logic [W-1:0] src = (s == 0) ? in_data : vot_o(s-1, r);
        nq[s][r] = en ? W'(src + 1) : m_q[s][r];
      end
    end
    for (int s = 0; s < S; s++) begin
      m_v[s] = nv[s];
      for (int r = 0; r < 3; r++) m_q[s][r] = nq[s][r];
    end
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      for (int s = 0; s < S; s++) begin
        m_v[s] = 1'b0;
        for (int r = 0; r < 3; r++) m_q[s][r] = '0;
      end
    end else begin
      model_edge();
    end
    @(negedge clk);
    chk(out_valid == m_v[S-1], "R2", "out_valid", out_valid, m_v[S-1]);
    chk(out_data == m_out(), "R4", "out_data", out_data, m_out());
    for (int s = 0; s < S; s++)
      chk(stage_mismatch[s] == m_mis(s), "R7", "stage_mismatch", stage_mismatch[s], m_mis(s));
  endtask

  task automatic send(input logic [W-1:0] d);
    in_data = d; in_valid = 1'b1;
    step();
    in_valid = 1'b0;
    in_data = ~d;
  endtask

  task automatic send_and_wait(input logic [W-1:0] d);
    send(d);
    step();
    step();
  endtask

  function automatic logic [W-1:0] plus_s(input logic [W-1:0] d);
    return W'(d + S);
  endfunction

  task automatic set_rep(input int s, input int r, input logic [W-1:0] m);
    rep_f[(s*3+r)*W +: W] = m;
  endtask

  task automatic set_vot(input int s, input int v, input logic [W-1:0] m);
    vot_f[(s*3+v)*W +: W] = m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(out_data == '0, "R1", "reset out_data", out_data, 0);
    chk(stage_mismatch == '0, "R1", "reset mismatch", stage_mismatch, 0);
    rst_n = 1'b1;
    step();
    chk(out_valid == 1'b0, "R1", "after release out_valid", out_valid, 0);

    // R2: latency of exactly S edges
    send(8'h10);
    chk(out_valid == 1'b0, "R2", "valid after 1 edge", out_valid, 0);
    step();
    chk(out_valid == 1'b0, "R2", "valid after 2 edges", out_valid, 0);
    step();
    chk(out_valid == 1'b1, "R2", "valid after 3 edges", out_valid, 1);
    chk(out_data == plus_s(8'h10), "R3", "increment", out_data, plus_s(8'h10));
    step();
    chk(out_valid == 1'b0, "R2", "single-cycle valid", out_valid, 0);

    // R3: wrap-around
    send_and_wait(8'hFE);
    chk(out_data == 8'h01, "R3", "wrap 0xFE", out_data, 8'h01);

    // back-to-back stream, compared cycle by cycle
    for (int i = 0; i < 24; i++) begin
      in_valid = 1'b1; in_data = W'(i * 37 + 5);
      step();
    end
    in_valid = 1'b0;
    repeat (4) step();

    // R5: single replica fault, mid stage and last stage
    set_rep(1, 2, 8'hFF);
    send_and_wait(8'h42);
    chk(out_data == plus_s(8'h42), "R5", "mid replica fault", out_data, plus_s(8'h42));
    chk(stage_mismatch[1] == 1'b1, "R7", "flag stage1", stage_mismatch[1], 1);
    chk(stage_mismatch[2] == 1'b0, "R7", "flag stage2 clean", stage_mismatch[2], 0);
    rep_f = '0;
    set_rep(S-1, 0, 8'h81);
    send_and_wait(8'h07);
    chk(out_data == plus_s(8'h07), "R5", "last replica fault", out_data, plus_s(8'h07));
    rep_f = '0;
    step();

    // R6: voter fault in first stage, flag appears one stage later
    set_vot(0, 1, 8'hA5);
    send_and_wait(8'h33);
    chk(out_data == plus_s(8'h33), "R6", "stage0 voter fault", out_data, plus_s(8'h33));
    chk(stage_mismatch[1] == 1'b1, "R7", "flag downstream of voter", stage_mismatch[1], 1);
    chk(stage_mismatch[0] == 1'b0, "R7", "flag at voter stage clean", stage_mismatch[0], 0);
    vot_f = '0;
    // R6: voter fault in last stage, only the end voter masks it
    set_vot(S-1, 0, 8'hFF);
    send_and_wait(8'h5C);
    chk(out_data == plus_s(8'h5C), "R6", "last voter fault", out_data, plus_s(8'h5C));
    vot_f = '0;
    step();

    // R8: one bad lane in every stage at once
    set_rep(0, 0, 8'h0F);
    set_rep(1, 1, 8'hF0);
    set_vot(1, 2, 8'h3C);
    set_rep(2, 2, 8'hFF);
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] d = W'(8'hC0 + i * 9);
      send_and_wait(d);
      chk(out_data == plus_s(d), "R8", "fault in every stage", out_data, plus_s(d));
    end
    rep_f = '0; vot_f = '0;
    step();

    // R4: two replicas of one stage corrupted on the same bit
    set_rep(S-1, 0, 8'h01);
    set_rep(S-1, 1, 8'h01);
    send_and_wait(8'h20);
    chk(out_data == (plus_s(8'h20) ^ 8'h01), "R4", "double fault flips bit",
        out_data, plus_s(8'h20) ^ 8'h01);
    rep_f = '0;
    step();

    // R9: hold with in_valid low and in_data changing
    send_and_wait(8'h77);
    chk(out_data == plus_s(8'h77), "R9", "loaded value", out_data, plus_s(8'h77));
    for (int i = 0; i < 8; i++) begin
      in_data = W'(i * 53 + 1);
      step();
      chk(out_data == plus_s(8'h77), "R9", "hold while idle", out_data, plus_s(8'h77));
      chk(out_valid == 1'b0, "R9", "no valid while idle", out_valid, 0);
    end

    finish_run();
  end
endmodule